// File: doc/BRIEF.md
# Pulse-Count Clock-Crossing Bridge

This block carries single-cycle event pulses from one clock domain into a second, unrelated clock domain without dropping any of them, however closely they are spaced. The sending side keeps a tally of events that have not yet been sent. Whenever no crossing is under way and the tally is nonzero, it copies the tally onto a held data bus, clears the tally and flips a request line. The receiving side synchronises the request, detects the flip, takes the bus value and flips an acknowledge line back. The sending side leaves the bus untouched until that acknowledge flip has been synchronised and detected.

On the receiving side the captured value is added to a down-counter. The output is high in every destination cycle while that counter is nonzero, and the counter drops by one in each of those cycles. The output therefore carries the same number of high cycles as there were input pulses. Their spacing is not kept. Pulses that arrive while a crossing is waiting for its acknowledge stay in the tally and go across in the next crossing.

Top module: `ptb_bridge`

## Requirements
- R1: While either reset is low, and after both resets have been released with no source pulse applied, `dst_pulse` is 0.
- R2: For any spacing of source pulses, back-to-back pulses included, and with either clock the faster one, the number of destination cycles with `dst_pulse` = 1 equals the number of source cycles with `src_pulse` = 1, once the bridge has gone quiet.
- R3: The source tally (`CNT_W` bits) and the destination down-counter (`CNT_W`+4 bits) never wrap. The stimulus keeps the number of pulses in flight (pulses in minus highs out) at or below 2^`CNT_W` - 1.
- R4: From the request flip until its acknowledge has been detected, the value on the crossing bus stays unchanged. Pulses that arrive during that time are not lost: they are delivered by a later crossing.
- R5: Only one crossing is ever outstanding: the request flips only when no acknowledge is awaited. A pulse that arrives while a crossing is waiting is seen at the output within three full round trips.
- R6: An isolated pulse produces its first `dst_pulse` high no later than 2 source periods plus 4 destination periods after the source cycle in which `src_pulse` was driven high.
- R7: An isolated pulse produces exactly one `dst_pulse` high cycle.
- R8: A pulse in the same source cycle as the start of a crossing is kept for the next crossing. Two pulses in consecutive source cycles give exactly two output highs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain synchronous reset, active low |
| src_pulse | input | 1 | Event input, high for one source cycle per event |
| dst_clk | input | 1 | Destination domain clock, unrelated to `src_clk` |
| dst_rst_n | input | 1 | Destination domain synchronous reset, active low |
| dst_pulse | output | 1 | One high destination cycle per source event |

## Verification
The assertions take it that `src_pulse` never arrives when the source tally is already at its all-ones value, and that a captured count always fits in the destination down-counter. Both hold only if the number of events in flight stays bounded. The stimulus keeps bursts to at most 20 back-to-back pulses and draws random gaps of up to 12 source cycles over a few hundred events. It also tracks pulses in minus highs out on every destination cycle and flags any excursion above 2^`CNT_W` - 1. The resets are released while `src_pulse` is low, and both domains are reset together, so the request and acknowledge toggles start out equal.

// File: rtl/ptb_pkg.sv
`timescale 1ns/1ps
// Package: shared defaults and types for the pulse-count bridge.
// Assumes: nothing; holds only constants and the source state type.
package ptb_pkg;
    localparam int PTB_CNT_W       = 6;  // default source tally / bus width
    localparam int PTB_REM_EXTRA   = 4;  // extra bits of destination down-counter
    localparam int PTB_SYNC_STAGES = 2;  // flops per synchroniser

    typedef enum logic {
        XFER_IDLE = 1'b0,
        XFER_WAIT = 1'b1
    } xfer_state_e;
endpackage

// File: rtl/ptb_sync.sv
`timescale 1ns/1ps
// Module: ptb_sync
// Multi-flop synchroniser for a single level (toggle) signal.
// Assumes: d changes at most once per several destination cycles;
// metastability itself is not modelled. STAGES >= 2.
module ptb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // First flop samples the asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= d;
                end
            end else begin : g_next
                // Later flops pass the value along the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/ptb_src_side.sv
`timescale 1ns/1ps
// Module: ptb_src_side
// Source half of the bridge: tallies input pulses, launches one crossing
// at a time by loading the tally onto a held bus and flipping a request,
// and waits for the returning acknowledge flip before launching again.
// Assumes: pulse_in is synchronous to clk; ack_tgl_in comes from the
// destination domain; the tally never has to exceed 2^CNT_W - 1.
module ptb_src_side
    import ptb_pkg::*;
#(
    parameter int CNT_W       = PTB_CNT_W,
    parameter int SYNC_STAGES = PTB_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_in,
    input  logic             ack_tgl_in,
    output logic             req_tgl_out,
    output logic [CNT_W-1:0] bus_out,
    output logic [CNT_W-1:0] pend_out,
    output logic             busy_out,
    output logic             ack_edge_out
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    xfer_state_e      state_q;
    logic [CNT_W-1:0] pend_q;
    logic [CNT_W-1:0] bus_q;
    logic             req_q;
    logic             ack_prev_q;
    logic             ack_s;
    logic             ack_edge;
    logic             start;

    ptb_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ack_tgl_in),
        .q     (ack_s)
    );

    assign ack_edge = ack_s ^ ack_prev_q;
    assign start    = (state_q == XFER_IDLE) && (pend_q != '0);

    // Remember the last synchronised acknowledge level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ack_prev_q <= 1'b0;
        else        ack_prev_q <= ack_s;
    end

    // Crossing state: idle until a launch, waiting until the acknowledge flip.
    always_ff @(posedge clk) begin
        if (!rst_n)                               state_q <= XFER_IDLE;
        else if (start)                           state_q <= XFER_WAIT;
        else if (state_q == XFER_WAIT && ack_edge) state_q <= XFER_IDLE;
    end

    // Held bus and request toggle: change only at a launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_q <= '0;
            req_q <= 1'b0;
        end else if (start) begin
            bus_q <= pend_q;
            req_q <= ~req_q;
        end
    end

    // Tally of pulses not yet launched; a pulse in a launch cycle is kept.
    always_ff @(posedge clk) begin
        if (!rst_n)        pend_q <= '0;
        else if (start)    pend_q <= pulse_in ? ONE : '0;
        else if (pulse_in) pend_q <= pend_q + ONE;
    end

    assign req_tgl_out  = req_q;
    assign bus_out      = bus_q;
    assign pend_out     = pend_q;
    assign busy_out     = (state_q == XFER_WAIT);
    assign ack_edge_out = ack_edge;
endmodule

// File: rtl/ptb_dst_side.sv
`timescale 1ns/1ps
// Module: ptb_dst_side
// Destination half of the bridge: detects each request flip, captures
// the held bus into a down-counter, flips the acknowledge, and drives
// one output high cycle per unit of the counter.
// Assumes: bus_in is stable whenever a request flip is detected; the
// remaining count fits in REM_W bits.
module ptb_dst_side
    import ptb_pkg::*;
#(
    parameter int CNT_W       = PTB_CNT_W,
    parameter int REM_W       = PTB_CNT_W + PTB_REM_EXTRA,
    parameter int SYNC_STAGES = PTB_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_tgl_in,
    input  logic [CNT_W-1:0] bus_in,
    output logic             ack_tgl_out,
    output logic             pulse_out,
    output logic [REM_W-1:0] rem_out,
    output logic             cap_out
);
    logic [REM_W-1:0] rem_q;
    logic [REM_W-1:0] rem_dec;
    logic [REM_W-1:0] rem_add;
    logic             req_s;
    logic             req_prev_q;
    logic             ack_q;
    logic             cap;

    ptb_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (req_tgl_in),
        .q     (req_s)
    );

    assign cap = req_s ^ req_prev_q;

    // Next-count terms: one unit spent per nonzero cycle, plus a new capture.
    always_comb begin
        rem_dec = rem_q - {{(REM_W-1){1'b0}}, (rem_q != '0)};
        rem_add = cap ? {{(REM_W-CNT_W){1'b0}}, bus_in} : '0;
    end

    // Remember the last synchronised request level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) req_prev_q <= 1'b0;
        else        req_prev_q <= req_s;
    end

    // Acknowledge toggle: flips once for every captured crossing.
    always_ff @(posedge clk) begin
        if (!rst_n)   ack_q <= 1'b0;
        else if (cap) ack_q <= ~ack_q;
    end

    // Down-counter of output highs still owed.
    always_ff @(posedge clk) begin
        if (!rst_n) rem_q <= '0;
        else        rem_q <= rem_dec + rem_add;
    end

    assign ack_tgl_out = ack_q;
    assign pulse_out   = (rem_q != '0);
    assign rem_out     = rem_q;
    assign cap_out     = cap;
endmodule

// File: rtl/ptb_bridge.sv
`timescale 1ns/1ps
// Module: ptb_bridge (top)
// Pulse-count clock-crossing bridge: joins the source and destination
// halves through a request toggle, a held count bus and an acknowledge
// toggle. Output highs equal input pulses in number, not in spacing.
// Assumes: the two clocks are unrelated; both resets are applied
// together at start-up; pulses in flight stay below 2^CNT_W.
module ptb_bridge
    import ptb_pkg::*;
#(
    parameter int CNT_W       = PTB_CNT_W,
    parameter int SYNC_STAGES = PTB_SYNC_STAGES
) (
    input  logic src_clk,
    input  logic src_rst_n,
    input  logic src_pulse,
    input  logic dst_clk,
    input  logic dst_rst_n,
    output logic dst_pulse
);
    localparam int REM_W = CNT_W + PTB_REM_EXTRA;

    logic             req_tgl;
    logic             ack_tgl;
    logic [CNT_W-1:0] xfer_bus;
    logic [CNT_W-1:0] pend;
    logic             busy;
    logic             ack_edge;
    logic [REM_W-1:0] rem;
    logic             cap;

    ptb_src_side #(
        .CNT_W       (CNT_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_src (
        .clk          (src_clk),
        .rst_n        (src_rst_n),
        .pulse_in     (src_pulse),
        .ack_tgl_in   (ack_tgl),
        .req_tgl_out  (req_tgl),
        .bus_out      (xfer_bus),
        .pend_out     (pend),
        .busy_out     (busy),
        .ack_edge_out (ack_edge)
    );

    ptb_dst_side #(
        .CNT_W       (CNT_W),
        .REM_W       (REM_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_dst (
        .clk         (dst_clk),
        .rst_n       (dst_rst_n),
        .req_tgl_in  (req_tgl),
        .bus_in      (xfer_bus),
        .ack_tgl_out (ack_tgl),
        .pulse_out   (dst_pulse),
        .rem_out     (rem),
        .cap_out     (cap)
    );
endmodule

// File: rtl/ptb_bridge_chk.sv
`timescale 1ns/1ps
// Module: ptb_bridge_chk
// Assertion checker for ptb_bridge, attached by bind below.
// Assumes: connected to the bridge's internal handshake nets.
module ptb_bridge_chk #(
    parameter int CNT_W = 6,
    parameter int REM_W = 10
) (
    input logic             src_clk,
    input logic             src_rst_n,
    input logic             src_pulse,
    input logic             busy,
    input logic             ack_edge,
    input logic             req_tgl,
    input logic [CNT_W-1:0] xfer_bus,
    input logic [CNT_W-1:0] pend,
    input logic             dst_clk,
    input logic             dst_rst_n,
    input logic             cap,
    input logic [REM_W-1:0] rem
);
    localparam logic [REM_W:0] REM_MAX = {1'b0, {REM_W{1'b1}}};

    logic [REM_W:0] rem_sum;
    assign rem_sum = {1'b0, rem} + {{(REM_W+1-CNT_W){1'b0}}, xfer_bus};

    AST_NO_OVERFLOW: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        (&pend) |-> !src_pulse); // R3

    AST_REM_NO_OVERFLOW: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        cap |-> (rem_sum <= REM_MAX)); // R3

    AST_BUS_HELD: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        busy |=> $stable(xfer_bus)); // R4

    AST_ONE_IN_FLIGHT: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        (busy && !ack_edge) |=> $stable(req_tgl)); // R5

    AST_NONZERO_XFER: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        $rose(busy) |-> (xfer_bus != '0)); // R2
endmodule

bind ptb_bridge ptb_bridge_chk #(
    .CNT_W (CNT_W),
    .REM_W (REM_W)
) chk_i (
    .src_clk   (src_clk),
    .src_rst_n (src_rst_n),
    .src_pulse (src_pulse),
    .busy      (busy),
    .ack_edge  (ack_edge),
    .req_tgl   (req_tgl),
    .xfer_bus  (xfer_bus),
    .pend      (pend),
    .dst_clk   (dst_clk),
    .dst_rst_n (dst_rst_n),
    .cap       (cap),
    .rem       (rem)
);

// File: tb/ptb_bridge_tb_top.sv
`timescale 1ns/1ps
// Directed bench for ptb_bridge: one task per scenario, run with the
// source at 125 MHz and the destination 7/5 slower, then swapped.
module ptb_bridge_tb_top;
    localparam int CNT_W     = 6;
    localparam int OUT_LIMIT = (1 << CNT_W) - 1;

    logic src_clk   = 1'b0;
    logic dst_clk   = 1'b0;
    logic src_rst_n = 1'b0;
    logic dst_rst_n = 1'b0;
    logic src_pulse = 1'b0;
    logic dst_pulse;

    real src_half = 4.0;
    real dst_half = 5.6;

    int n_in     = 0;
    int n_out    = 0;
    int checks   = 0;
    int errors   = 0;
    bit ovf_seen = 1'b0;
    bit done     = 1'b0;

    ptb_bridge #(.CNT_W(CNT_W)) dut_i (
        .src_clk   (src_clk),
        .src_rst_n (src_rst_n),
        .src_pulse (src_pulse),
        .dst_clk   (dst_clk),
        .dst_rst_n (dst_rst_n),
        .dst_pulse (dst_pulse)
    );

    initial forever #(src_half) src_clk = ~src_clk;
    initial forever #(dst_half) dst_clk = ~dst_clk;

    // Count output highs and watch pulses in flight, away from the edge.
    always @(negedge dst_clk) begin
        if (dst_rst_n && dst_pulse) n_out++;
        if ((n_in - n_out) > OUT_LIMIT) ovf_seen = 1'b1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic apply_reset();
        @(negedge src_clk);
        src_rst_n = 1'b0;
        dst_rst_n = 1'b0;
        src_pulse = 1'b0;
        repeat (6) @(negedge dst_clk);
        check(dst_pulse == 1'b0, "R1", "dst_pulse during reset", dst_pulse, 0);
        n_in = 0; n_out = 0; ovf_seen = 1'b0;
        @(negedge src_clk) src_rst_n = 1'b1;
        @(negedge dst_clk) dst_rst_n = 1'b1;
    endtask

    task automatic drive_pulses(input int count);
        for (int i = 0; i < count; i++) begin
            @(negedge src_clk);
            src_pulse = 1'b1;
            n_in++;
        end
        @(negedge src_clk) src_pulse = 1'b0;
    endtask

    task automatic drain();
        repeat (200) @(negedge dst_clk);
    endtask

    task automatic t_reset_quiet();
        apply_reset();
        repeat (30) @(negedge dst_clk);
        check(n_out == 0, "R1", "highs with no input after reset", n_out, 0);
    endtask

    task automatic t_single();
        realtime t0, lat, bound;
        int      waited = 0;
        drain();
        n_in = 0; n_out = 0;
        @(negedge src_clk);
        src_pulse = 1'b1; n_in++;
        t0 = $realtime;
        @(negedge src_clk) src_pulse = 1'b0;
        while (n_out == 0 && waited < 60) begin
            @(negedge dst_clk);
            waited++;
        end
        lat   = $realtime - t0;
        bound = 4.0 * src_half + 8.0 * dst_half;
        check(lat <= bound, "R6", "first high latency ns", int'(lat), int'(bound));
        drain();
        check(n_out == 1, "R7", "highs from one pulse", n_out, 1);
    endtask

    task automatic t_pair();
        drain();
        n_in = 0; n_out = 0;
        drive_pulses(2);
        drain();
        check(n_out == 2, "R8", "highs from two adjacent pulses", n_out, 2);
    endtask

    task automatic t_burst(input int len);
        drain();
        n_in = 0; n_out = 0; ovf_seen = 1'b0;
        drive_pulses(len);
        drain();
        check(n_out == len, "R2", "highs from burst", n_out, len);
        check(!ovf_seen, "R3", "in-flight bound exceeded", int'(ovf_seen), 0);
    endtask

    task automatic t_in_flight();
        int window;
        drain();
        n_in = 0; n_out = 0;
        drive_pulses(1);
        repeat (2) @(negedge src_clk);
        drive_pulses(1);
        repeat (3) @(negedge src_clk);
        drive_pulses(1);
        window = 3 * (5 * int'(2.0 * src_half) + 5 * int'(2.0 * dst_half));
        #(window);
        check(n_out == 3, "R5", "highs within three round trips", n_out, 3);
        drain();
        check(n_out == 3, "R4", "pulses during a wait kept", n_out, 3);
    endtask

    task automatic t_random(input int count);
        drain();
        n_in = 0; n_out = 0; ovf_seen = 1'b0;
        for (int i = 0; i < count; i++) begin
            int gap = int'($urandom_range(0, 12));
            drive_pulses(1);
            if (gap > 0) repeat (gap - 1) @(negedge src_clk);
        end
        drain();
        check(n_out == n_in, "R2", "highs from random pulses", n_out, n_in);
        check(!ovf_seen, "R3", "in-flight bound exceeded", int'(ovf_seen), 0);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            summary();
        end
    end

    initial begin
        t_reset_quiet();
        t_single();
        t_pair();
        t_burst(20);
        t_in_flight();
        t_random(300);

        src_half = 5.6;
        dst_half = 4.0;
        apply_reset();
        t_single();
        t_pair();
        t_burst(20);
        t_in_flight();
        t_random(300);

        done = 1'b1;
        summary();
    end
endmodule